// File: doc/BRIEF.md
# Operand Forwarding and Stall Controller

This block is the central hazard unit of a six-stage in-order pipeline: fetch, decode, execute, a second execute stage that also writes condition flags, memory, and writeback. It takes the two source register numbers of the instruction sitting in decode. It compares them with the destination of every older instruction still in flight, which lives in the execute, second-execute, memory and writeback stages. For each source operand it produces a select code for the operand mux outside the block. The code chooses between the register file and one of the four in-flight stages.

The block is combinational. Each in-flight stage reports three things: a valid bit, a destination register number, and a 2-bit result class. The class tells the block in which stage the result first exists. If the youngest matching stage holds a value that is not computed yet, the block holds fetch and decode and pushes a bubble into execute. A multi-cycle data memory access holds the whole pipeline, and no bubble is inserted while it does.

Top module: `fwd_stall_ctrl`

## Requirements
- R1: `fwd_sel_*_o` codes are 0 = register file, 1 = execute, 2 = second execute, 3 = memory, 4 = writeback. For a used operand, the code names the matching stage when that stage's result is ready. When no stage matches, the code is 0.
- R2: A stage matches an operand only if all of these hold: the stage is valid, its destination is non-zero, and its destination equals the source number. A source of register 0, or an operand whose use bit is low, always gives code 0 and never causes a stall.
- R3: When several stages match, only the youngest one counts. The order from youngest to oldest is execute, second execute, memory, writeback.
- R4: Class codes are 0 = simple ALU, 1 = 16-bit multiply, 2 = 32-bit multiply, 3 = load. The earliest stage in which each result is ready is: execute for class 0, second execute for class 1, memory for class 2, writeback for class 3.
- R5: If the youngest matching stage is not yet ready, that operand's code is 0 and the block raises both `stall_fd_o` and `bubble_ex_o`. The block never falls back to an older matching stage.
- R6: The two operands are resolved independently. A hazard on either one stalls decode.
- R7: While `mem_busy_i` is high, `freeze_o` and `stall_fd_o` are high and `bubble_ex_o` is low, whatever the operand hazards are.
- R8: While `dec_valid_i` is low, both codes are 0 and `bubble_ex_o` is low. In that case `stall_fd_o` follows only `mem_busy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid_i | input | 1 | Decode stage holds an instruction |
| use_a_i | input | 1 | Operand A is read |
| src_a_i | input | REG_W | Operand A register number |
| use_b_i | input | 1 | Operand B is read |
| src_b_i | input | REG_W | Operand B register number |
| ex_valid_i | input | 1 | Execute stage valid |
| ex_dest_i | input | REG_W | Execute stage destination |
| ex_cls_i | input | 2 | Execute stage result class |
| x2_valid_i | input | 1 | Second execute stage valid |
| x2_dest_i | input | REG_W | Second execute stage destination |
| x2_cls_i | input | 2 | Second execute stage result class |
| mem_valid_i | input | 1 | Memory stage valid |
| mem_dest_i | input | REG_W | Memory stage destination |
| mem_cls_i | input | 2 | Memory stage result class |
| wb_valid_i | input | 1 | Writeback stage valid |
| wb_dest_i | input | REG_W | Writeback stage destination |
| wb_cls_i | input | 2 | Writeback stage result class |
| mem_busy_i | input | 1 | Data memory access not yet complete |
| fwd_sel_a_o | output | 3 | Forwarding select, operand A |
| fwd_sel_b_o | output | 3 | Forwarding select, operand B |
| stall_fd_o | output | 1 | Hold fetch and decode registers |
| bubble_ex_o | output | 1 | Load an empty slot into execute |
| freeze_o | output | 1 | Hold every pipeline stage |

## Verification
The bench builds the block with `REG_W` = 2, which gives four registers. With that setting, every single-stage combination of valid bit, destination, class and source can be swept in full. The same holds for every pair of matching stages across all class pairs, and for every class pairing on two independent operands. A long pseudo-random walk then covers mixed cases across all four stages, including the memory-busy and empty-decode inputs, and compares each result with an arithmetic readiness model.

// File: rtl/fwd_stall_pkg.sv
package fwd_stall_pkg;

  localparam int unsigned N_FWD_ST = 4;
  localparam int unsigned SEL_W    = 3;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_MUL16 = 2'd1,
    CLS_MUL32 = 2'd2,
    CLS_LOAD  = 2'd3
  } res_cls_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 3'd0,
    SEL_EX  = 3'd1,
    SEL_X2  = 3'd2,
    SEL_MEM = 3'd3,
    SEL_WB  = 3'd4
  } fwd_sel_e;

  // first stage position (1 = execute .. 4 = writeback) holding the result
  function automatic int unsigned ready_pos(input res_cls_e cls);
    case (cls)
      CLS_ALU:   return 1;
      CLS_MUL16: return 2;
      CLS_MUL32: return 3;
      default:   return 4;
    endcase
  endfunction

endpackage

// File: rtl/fwd_stage_ready.sv
module fwd_stage_ready
  import fwd_stall_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned ST_POS = 1
) (
  input  logic             valid_i,
  input  logic [REG_W-1:0] dest_i,
  input  logic [1:0]       cls_i,
  output logic             writes_o,
  output logic             ready_o
);

  res_cls_e cls;

  always_comb begin
    cls      = res_cls_e'(cls_i);
    writes_o = valid_i && (dest_i != '0);
    ready_o  = (ST_POS >= ready_pos(cls));
  end

endmodule

// File: rtl/fwd_operand_resolve.sv
module fwd_operand_resolve
  import fwd_stall_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned N_ST   = N_FWD_ST
) (
  input  logic                 en_i,
  input  logic [REG_W-1:0]     src_i,
  input  logic [N_ST-1:0]      writes_i,
  input  logic [REG_W-1:0]     dest_i [N_ST],
  input  logic [N_ST-1:0]      ready_i,
  output logic [SEL_W-1:0]     sel_o,
  output logic                 hazard_o
);

  logic [N_ST-1:0] hit;

  for (genvar g = 0; g < N_ST; g++) begin : g_hit
    assign hit[g] = writes_i[g] && (dest_i[g] == src_i);
  end

  // scan oldest to youngest so the youngest hit wins
  always_comb begin
    sel_o    = SEL_RF;
    hazard_o = 1'b0;
    if (en_i && (src_i != '0)) begin
      for (int i = N_ST - 1; i >= 0; i--) begin
        if (hit[i]) begin
          sel_o    = ready_i[i] ? SEL_W'(i + 1) : SEL_RF;
          hazard_o = !ready_i[i];
        end
      end
    end
  end

  always_comb begin
    assert_sel_range_R1: assert (sel_o <= SEL_W'(N_ST));
    if (sel_o != SEL_RF)
      assert_no_r0_fwd_R2: assert (en_i && src_i != '0);
    if (hazard_o)
      assert_haz_no_fwd_R5: assert (sel_o == SEL_RF);
  end

endmodule

// File: rtl/fwd_stall_gen.sv
module fwd_stall_gen (
  input  logic dec_valid_i,
  input  logic hazard_a_i,
  input  logic hazard_b_i,
  input  logic mem_busy_i,
  output logic stall_fd_o,
  output logic bubble_ex_o,
  output logic freeze_o
);

  logic dep_stall;

  always_comb begin
    dep_stall   = dec_valid_i && (hazard_a_i || hazard_b_i);
    freeze_o    = mem_busy_i;
    stall_fd_o  = dep_stall || mem_busy_i;
    bubble_ex_o = dep_stall && !mem_busy_i;
  end

endmodule

// File: rtl/fwd_stall_ctrl.sv
module fwd_stall_ctrl
  import fwd_stall_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             dec_valid_i,
  input  logic             use_a_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic             use_b_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic             ex_valid_i,
  input  logic [REG_W-1:0] ex_dest_i,
  input  logic [1:0]       ex_cls_i,
  input  logic             x2_valid_i,
  input  logic [REG_W-1:0] x2_dest_i,
  input  logic [1:0]       x2_cls_i,
  input  logic             mem_valid_i,
  input  logic [REG_W-1:0] mem_dest_i,
  input  logic [1:0]       mem_cls_i,
  input  logic             wb_valid_i,
  input  logic [REG_W-1:0] wb_dest_i,
  input  logic [1:0]       wb_cls_i,
  input  logic             mem_busy_i,
  output logic [2:0]       fwd_sel_a_o,
  output logic [2:0]       fwd_sel_b_o,
  output logic             stall_fd_o,
  output logic             bubble_ex_o,
  output logic             freeze_o
);

  localparam int unsigned N_OPS = 2;

  logic [N_FWD_ST-1:0] st_valid, st_writes, st_ready;
  logic [REG_W-1:0]    st_dest [N_FWD_ST];
  logic [1:0]          st_cls  [N_FWD_ST];

  logic [N_OPS-1:0]    op_en, op_haz;
  logic [REG_W-1:0]    op_src [N_OPS];
  logic [SEL_W-1:0]    op_sel [N_OPS];

  // index 0 is youngest
  assign st_valid = {wb_valid_i, mem_valid_i, x2_valid_i, ex_valid_i};
  assign st_dest[0] = ex_dest_i;
  assign st_dest[1] = x2_dest_i;
  assign st_dest[2] = mem_dest_i;
  assign st_dest[3] = wb_dest_i;
  assign st_cls[0]  = ex_cls_i;
  assign st_cls[1]  = x2_cls_i;
  assign st_cls[2]  = mem_cls_i;
  assign st_cls[3]  = wb_cls_i;

  for (genvar s = 0; s < N_FWD_ST; s++) begin : g_stage
    fwd_stage_ready #(
      .REG_W  (REG_W),
      .ST_POS (s + 1)
    ) u_ready (
      .valid_i  (st_valid[s]),
      .dest_i   (st_dest[s]),
      .cls_i    (st_cls[s]),
      .writes_o (st_writes[s]),
      .ready_o  (st_ready[s])
    );
  end

  assign op_en  = {dec_valid_i && use_b_i, dec_valid_i && use_a_i};
  assign op_src[0] = src_a_i;
  assign op_src[1] = src_b_i;

  for (genvar o = 0; o < N_OPS; o++) begin : g_op
    fwd_operand_resolve #(
      .REG_W (REG_W),
      .N_ST  (N_FWD_ST)
    ) u_resolve (
      .en_i     (op_en[o]),
      .src_i    (op_src[o]),
      .writes_i (st_writes),
      .dest_i   (st_dest),
      .ready_i  (st_ready),
      .sel_o    (op_sel[o]),
      .hazard_o (op_haz[o])
    );
  end

  fwd_stall_gen u_stall (
    .dec_valid_i (dec_valid_i),
    .hazard_a_i  (op_haz[0]),
    .hazard_b_i  (op_haz[1]),
    .mem_busy_i  (mem_busy_i),
    .stall_fd_o  (stall_fd_o),
    .bubble_ex_o (bubble_ex_o),
    .freeze_o    (freeze_o)
  );

  assign fwd_sel_a_o = op_sel[0];
  assign fwd_sel_b_o = op_sel[1];

  always_comb begin
    if (freeze_o)
      assert_busy_no_bubble_R7: assert (!bubble_ex_o && stall_fd_o);
    if (!dec_valid_i)
      assert_idle_quiet_R8: assert (!bubble_ex_o && fwd_sel_a_o == 3'd0 && fwd_sel_b_o == 3'd0);
    if (bubble_ex_o)
      assert_bubble_has_wait_R6: assert (op_haz != '0 && stall_fd_o);
  end

endmodule

// File: tb/fwd_stall_ctrl_bench.sv
module fwd_stall_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned RW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          dec_valid, use_a, use_b, mem_busy;
  logic [RW-1:0] src_a, src_b;
  logic          v [4];
  logic [RW-1:0] d [4];
  logic [1:0]    c [4];
  logic [2:0]    sel_a, sel_b;
  logic          stall_fd, bubble_ex, freeze;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  fwd_stall_ctrl #(.REG_W(RW)) u_fwd_stall_ctrl (
    .dec_valid_i (dec_valid), .use_a_i (use_a), .src_a_i (src_a),
    .use_b_i (use_b), .src_b_i (src_b),
    .ex_valid_i (v[0]), .ex_dest_i (d[0]), .ex_cls_i (c[0]),
    .x2_valid_i (v[1]), .x2_dest_i (d[1]), .x2_cls_i (c[1]),
    .mem_valid_i (v[2]), .mem_dest_i (d[2]), .mem_cls_i (c[2]),
    .wb_valid_i (v[3]), .wb_dest_i (d[3]), .wb_cls_i (c[3]),
    .mem_busy_i (mem_busy),
    .fwd_sel_a_o (sel_a), .fwd_sel_b_o (sel_b),
    .stall_fd_o (stall_fd), .bubble_ex_o (bubble_ex), .freeze_o (freeze)
  );

  // stage i (0 = execute) holds class k's result once i >= k
  function automatic void model(input logic en, input logic [RW-1:0] src,
                                output int sel, output bit haz);
    sel = 0; haz = 0;
    if (!en || src == 0) return;
    for (int i = 3; i >= 0; i--) begin
      if (v[i] && d[i] != 0 && d[i] == src) begin
        if (i >= int'(c[i])) begin sel = i + 1; haz = 0; end
        else begin sel = 0; haz = 1; end
      end
    end
  endfunction

  task automatic clear_all();
    dec_valid = 0; use_a = 0; use_b = 0; mem_busy = 0; src_a = 0; src_b = 0;
    for (int i = 0; i < 4; i++) begin v[i] = 0; d[i] = 0; c[i] = 0; end
  endtask

  task automatic check(input string tag);
    int  ea, eb;
    bit  ha, hb, es, ebub, efr;
    #2;
    model(dec_valid && use_a, src_a, ea, ha);
    model(dec_valid && use_b, src_b, eb, hb);
    es   = (dec_valid && (ha || hb)) || mem_busy;
    ebub = dec_valid && (ha || hb) && !mem_busy;
    efr  = mem_busy;
    n_tests++;
    if (int'(sel_a) != ea || int'(sel_b) != eb || stall_fd != es ||
        bubble_ex != ebub || freeze != efr) begin
      n_fail++;
      $display("FAIL %s: sel_a=%0d sel_b=%0d stall=%0b bubble=%0b freeze=%0b expected %0d %0d %0b %0b %0b",
               tag, sel_a, sel_b, stall_fd, bubble_ex, freeze, ea, eb, es, ebub, efr);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    clear_all();
    @(negedge clk);
    check("R8 idle");

    // single stage: all valid/dest/class/src combinations, operand A only
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++)
        for (int sr = 0; sr < 4; sr++)
          for (int ds = 0; ds < 4; ds++)
            for (int vv = 0; vv < 2; vv++) begin
              @(negedge clk);
              clear_all();
              dec_valid = 1; use_a = 1; src_a = RW'(sr);
              v[s] = vv[0]; d[s] = RW'(ds); c[s] = k[1:0];
              if (sr == 0 || vv == 0 || ds == 0) check("R2 no match");
              else if (ds != sr) check("R1 regfile");
              else if (s >= k) check("R4 ready fwd");
              else check("R5 not ready");
            end

    // unused operand never matches
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      clear_all();
      dec_valid = 1; use_a = 0; src_a = 1; v[0] = 1; d[0] = 1; c[0] = k[1:0];
      check("R2 unused");
    end

    // two matching stages: the younger decides
    for (int y = 0; y < 4; y++)
      for (int o = y + 1; o < 4; o++)
        for (int ky = 0; ky < 4; ky++)
          for (int ko = 0; ko < 4; ko++) begin
            @(negedge clk);
            clear_all();
            dec_valid = 1; use_b = 1; src_b = 2;
            v[y] = 1; d[y] = 2; c[y] = ky[1:0];
            v[o] = 1; d[o] = 2; c[o] = ko[1:0];
            check("R3 youngest");
          end

    // independent operands on different stages
    for (int ka = 0; ka < 4; ka++)
      for (int kb = 0; kb < 4; kb++)
        for (int sa = 0; sa < 4; sa++) begin
          @(negedge clk);
          clear_all();
          dec_valid = 1; use_a = 1; use_b = 1; src_a = 1; src_b = 3;
          v[sa] = 1; d[sa] = 1; c[sa] = ka[1:0];
          v[3 - sa] = 1; d[3 - sa] = 3; c[3 - sa] = kb[1:0];
          check("R6 two operands");
        end

    // memory busy over load-use and clean cases
    for (int k = 0; k < 4; k++)
      for (int dv = 0; dv < 2; dv++) begin
        @(negedge clk);
        clear_all();
        dec_valid = dv[0]; use_a = 1; src_a = 1; v[0] = 1; d[0] = 1; c[0] = k[1:0];
        mem_busy = 1;
        check("R7 busy");
      end

    // decode empty with pending load in execute
    @(negedge clk);
    clear_all();
    use_a = 1; use_b = 1; src_a = 1; src_b = 1; v[0] = 1; d[0] = 1; c[0] = 2'd3;
    check("R8 empty decode");

    // pseudo-random mix
    lfsr = 16'hace1;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v[i] = lfsr[0] | lfsr[5];
        d[i] = lfsr[2:1];
        c[i] = lfsr[4:3];
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src_a = lfsr[1:0]; src_b = lfsr[3:2];
      use_a = lfsr[4] | lfsr[8]; use_b = lfsr[5] | lfsr[9];
      dec_valid = lfsr[6] | lfsr[10];
      mem_busy = lfsr[7] & lfsr[11] & lfsr[12];
      check("R1 R6 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule